// File: doc/BRIEF.md
# Cascadable Signed 18x18 Multiplier

This block multiplies two signed 18-bit operands into a signed 36-bit product. The second operand has two possible sources: a direct input port, or a dedicated 18-bit chain input driven by a neighbouring multiplier. A static parameter picks the source. The picked operand may pass through an optional pipeline register. Whatever value actually reaches the multiplier is driven out on an 18-bit chain output. A row of these blocks can therefore share one operand, with each stage feeding the next.

The first operand and the product each have their own optional register. Each register has its own clock enable and its own synchronous clear. An asynchronous active-low reset clears every register that is present. With all three registers bypassed, the block is purely combinational. With all three present, a product appears two cycles after its operands.

Top module: `casc_mul18`

## Requirements
- R1: `p_o` is the signed two's-complement product of the operand values that reach the multiplier. This includes (-131072)×(-131072) = 2^34.
- R2: With `BSRC` = `BSRC_PORT` (0), the second operand is taken from `b_i` and `bchain_i` has no effect. With `BSRC` = `BSRC_CHAIN` (1), it is taken from `bchain_i` and `b_i` has no effect.
- R3: `bchain_o` always equals the second operand applied to the multiplier. This is the register output when `USE_BREG`=1, and the selected input when `USE_BREG`=0.
- R4: The product reflects a new A operand after `USE_AREG`+`USE_PREG` rising edges, and a new B operand after `USE_BREG`+`USE_PREG` rising edges.
- R5: A present register loads on a rising edge when its enable is 1, and holds its value when its enable is 0.
- R6: A synchronous clear forces only its own register to zero on the next rising edge. It wins over that register's enable.
- R7: For a bypassed register, its enable and clear inputs have no effect on the outputs.
- R8: While `rst_n` is 0, every present register is zero. With all registers present, `p_o` and `bchain_o` are 0.
- R9: In a chain of stages with `USE_BREG`=1 linked from `bchain_o` to `bchain_i`, a new shared operand appears at each stage's `bchain_o` exactly one cycle after it appears at the previous stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | First operand, signed |
| b_i | input | 18 | Second operand from the direct port, signed |
| bchain_i | input | 18 | Second operand from the previous stage |
| a_en | input | 1 | Clock enable, A register |
| b_en | input | 1 | Clock enable, B register |
| p_en | input | 1 | Clock enable, product register |
| a_clr | input | 1 | Synchronous clear, A register |
| b_clr | input | 1 | Synchronous clear, B register |
| p_clr | input | 1 | Synchronous clear, product register |
| p_o | output | 36 | Signed product |
| bchain_o | output | 18 | Second operand as applied, for the next stage |

## Verification
In a fully registered stage, `bchain_o` is due one edge after the B operand is captured, and `p_o` is due two edges after both operands are captured. Each further chained stage adds one edge to both. The bench changes inputs on falling edges and samples on later falling edges. For table vectors it waits five edges, which is enough for the deepest stage. The latency test counts edges one at a time and checks at each step that the old value is still present where the new one is not yet due. The combinational instance is sampled in the same half cycle in which its inputs change.

// File: rtl/casc_mul_pkg.sv
package casc_mul_pkg;
  // Source of the second multiplier operand
  typedef enum logic {
    BSRC_PORT  = 1'b0,
    BSRC_CHAIN = 1'b1
  } bsrc_e;
endpackage

// File: rtl/cm_opt_reg.sv
// Optional pipeline register: sync clear over enable, async active-low reset
module cm_opt_reg #(
  parameter int W  = 18,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nx;

      always_comb begin
        q_nx = q_r;
        if (clr)     q_nx = '0;
        else if (en) q_nx = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nx;
      end

      assign q = q_r;

      // R5
      ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (q == $past(d)));
      // R5
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(q));
      // R6
      clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    end else begin : g_thru
      logic unused_ctl;
      assign unused_ctl = ^{en, clr, clk, rst_n};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/cm_bsel.sv
// Static selection of the second operand source
module cm_bsel #(
  parameter int                  W    = 18,
  parameter casc_mul_pkg::bsrc_e BSRC = casc_mul_pkg::BSRC_PORT
) (
  input  logic [W-1:0] port_i,
  input  logic [W-1:0] chain_i,
  output logic [W-1:0] sel_o
);
  generate
    if (BSRC == casc_mul_pkg::BSRC_CHAIN) begin : g_chain
      logic unused_port;
      assign unused_port = ^port_i;
      assign sel_o = chain_i;
    end else begin : g_port
      logic unused_chain;
      assign unused_chain = ^chain_i;
      assign sel_o = port_i;
    end
  endgenerate
endmodule

// File: rtl/cm_smul.sv
// Signed W x W multiplier, full-width product
module cm_smul #(
  parameter int W = 18
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] a_x;
  logic signed [PW-1:0] b_x;

  always_comb begin
    a_x = {{W{a[W-1]}}, a};
    b_x = {{W{b[W-1]}}, b};
    p   = a_x * b_x;
  end

  always_comb begin
    // R1
    if (a == '0 || b == '0) begin
      zero_chk: assert (p == '0);
    end
    // R1
    if (a != '0 && b != '0) begin
      sign_chk: assert (p[PW-1] == (a[W-1] ^ b[W-1]));
    end
  end
endmodule

// File: rtl/casc_mul18.sv
// Cascadable signed multiplier with optional A, B and product registers
module casc_mul18 #(
  parameter int                  OPW      = 18,
  parameter casc_mul_pkg::bsrc_e BSRC     = casc_mul_pkg::BSRC_PORT,
  parameter bit                  USE_AREG = 1'b1,
  parameter bit                  USE_BREG = 1'b1,
  parameter bit                  USE_PREG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPW-1:0]       a_i,
  input  logic [OPW-1:0]       b_i,
  input  logic [OPW-1:0]       bchain_i,
  input  logic                 a_en,
  input  logic                 b_en,
  input  logic                 p_en,
  input  logic                 a_clr,
  input  logic                 b_clr,
  input  logic                 p_clr,
  output logic [2*OPW-1:0]     p_o,
  output logic [OPW-1:0]       bchain_o
);
  localparam int PW = 2 * OPW;

  logic [OPW-1:0] b_sel;
  logic [OPW-1:0] a_op;
  logic [OPW-1:0] b_op;
  logic [PW-1:0]  prod;

  cm_bsel #(.W(OPW), .BSRC(BSRC)) u_bsel (
    .port_i (b_i),
    .chain_i(bchain_i),
    .sel_o  (b_sel)
  );

  cm_opt_reg #(.W(OPW), .EN(USE_AREG)) u_areg (
    .clk(clk), .rst_n(rst_n), .en(a_en), .clr(a_clr), .d(a_i), .q(a_op)
  );

  cm_opt_reg #(.W(OPW), .EN(USE_BREG)) u_breg (
    .clk(clk), .rst_n(rst_n), .en(b_en), .clr(b_clr), .d(b_sel), .q(b_op)
  );

  cm_smul #(.W(OPW)) u_mul (
    .a(a_op),
    .b(b_op),
    .p(prod)
  );

  cm_opt_reg #(.W(PW), .EN(USE_PREG)) u_preg (
    .clk(clk), .rst_n(rst_n), .en(p_en), .clr(p_clr), .d(prod), .q(p_o)
  );

  // The operand forwarded downstream is the one that was multiplied
  assign bchain_o = b_op;
endmodule

// File: tb/casc_mul18_tb.sv
module casc_mul18_tb;
  localparam int W = 18;
  localparam int NV = 8;
  // {a, b} pairs
  localparam logic [2*W-1:0] VEC [NV] = '{
    {18'h00001, 18'h00001},
    {18'h3FFFF, 18'h00001},
    {18'h20000, 18'h20000},
    {18'h1FFFF, 18'h1FFFF},
    {18'h20000, 18'h1FFFF},
    {18'h00000, 18'h03039},
    {18'h3FFFB, 18'h00007},
    {18'h003E8, 18'h3F448}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a, b, noise;
  logic a_en, b_en, p_en, a_clr, b_clr, p_clr;
  logic [2*W-1:0] p0, p1, p2, pc;
  logic [W-1:0] c0, c1, c2, cc;
  int ncheck = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  casc_mul18 u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .bchain_i(noise),
    .a_en(a_en), .b_en(b_en), .p_en(p_en),
    .a_clr(a_clr), .b_clr(b_clr), .p_clr(p_clr),
    .p_o(p0), .bchain_o(c0)
  );

  casc_mul18 #(.BSRC(casc_mul_pkg::BSRC_CHAIN)) u_s1 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(noise), .bchain_i(c0),
    .a_en(1'b1), .b_en(1'b1), .p_en(1'b1),
    .a_clr(1'b0), .b_clr(1'b0), .p_clr(1'b0),
    .p_o(p1), .bchain_o(c1)
  );

  casc_mul18 #(.BSRC(casc_mul_pkg::BSRC_CHAIN)) u_s2 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(noise), .bchain_i(c1),
    .a_en(1'b1), .b_en(1'b1), .p_en(1'b1),
    .a_clr(1'b0), .b_clr(1'b0), .p_clr(1'b0),
    .p_o(p2), .bchain_o(c2)
  );

  // All registers bypassed, chain source; enables off and clears on
  casc_mul18 #(.BSRC(casc_mul_pkg::BSRC_CHAIN), .USE_AREG(1'b0),
               .USE_BREG(1'b0), .USE_PREG(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(~b), .bchain_i(b),
    .a_en(1'b0), .b_en(1'b0), .p_en(1'b0),
    .a_clr(1'b1), .b_clr(1'b1), .p_clr(1'b1),
    .p_o(pc), .bchain_o(cc)
  );

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y);
    logic signed [2*W-1:0] sx, sy;
    sx = {{W{x[W-1]}}, x};
    sy = {{W{y[W-1]}}, y};
    return sx * sy;
  endfunction

  task automatic chk(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    ncheck++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    ncheck++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a = 18'h12345; b = 18'h0ABCD; noise = 18'h2AAAA;
    a_en = 1'b1; b_en = 1'b1; p_en = 1'b1;
    a_clr = 1'b0; b_clr = 1'b0; p_clr = 1'b0;
    edges(3);
    // R8: registers held at zero during reset despite active inputs
    chk("R8 p0 in reset", p0, '0);
    chk("R8 c0 in reset", {18'h0, c0}, '0);
    chk("R8 p2 in reset", p2, '0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      a = VEC[i][2*W-1:W];
      b = VEC[i][W-1:0];
      #1;
      chk("R2 R7 comb product", pc, ref_mul(a, b));
      chk("R3 comb chain out", {18'h0, cc}, {18'h0, b});
      edges(5);
      chk("R1 R2 stage0 product", p0, ref_mul(a, b));
      chk("R9 stage1 product", p1, ref_mul(a, b));
      chk("R9 stage2 product", p2, ref_mul(a, b));
      chk("R3 stage2 chain out", {18'h0, c2}, {18'h0, b});
    end

    // R4 R9: one-cycle step per stage
    a = 18'h00003; b = 18'h00004;
    edges(5);
    b = 18'h00006;
    edges(1);
    chk("R3 R9 c0 after 1", {18'h0, c0}, 36'd6);
    chk("R9 c1 after 1", {18'h0, c1}, 36'd4);
    chk("R4 p0 after 1", p0, 36'd12);
    edges(1);
    chk("R4 p0 after 2", p0, 36'd18);
    chk("R9 c1 after 2", {18'h0, c1}, 36'd6);
    chk("R9 c2 after 2", {18'h0, c2}, 36'd4);
    edges(1);
    chk("R9 c2 after 3", {18'h0, c2}, 36'd6);

    // R5: hold with b_en low
    a = 18'h00003; b = 18'h00005;
    edges(2);
    b_en = 1'b0; b = 18'h00007;
    edges(2);
    chk("R5 b held", {18'h0, c0}, 36'd5);
    chk("R5 product with held b", p0, 36'd15);

    // R6: clear beats enable, touches only its own register
    b_en = 1'b1; b_clr = 1'b1; b = 18'h00009;
    edges(1);
    chk("R6 b clear over enable", {18'h0, c0}, '0);
    b_clr = 1'b0; b = 18'h00002; a_en = 1'b0; a = 18'h00064;
    edges(2);
    chk("R5 R6 a kept, b reloaded", p0, 36'd6);
    p_clr = 1'b1;
    edges(1);
    chk("R6 p clear", p0, '0);
    chk("R6 b untouched by p clear", {18'h0, c0}, 36'd2);
    p_clr = 1'b0;
    edges(1);
    chk("R6 p reload", p0, 36'd6);

    // R8: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R8 p0 async", p0, '0);
    chk("R8 c1 async", {18'h0, c1}, '0);

    $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
    $finish;
  end
endmodule